// File: doc/BRIEF.md
# Signed Word Divider with Condition Flags

This block divides one signed 32-bit word by another and produces the quotient after a fixed number of cycles. When asked, it also updates a 4-bit condition field. The field holds the sign of the result (less than, greater than or equal to zero) and a sticky summary-overflow bit. The core is a radix-2 restoring iteration that works on operand magnitudes. The result sign is applied at the end. The quotient truncates toward zero.

Two operand pairs have no true quotient: any divisor of zero, and the most negative word divided by minus one. For both, the block returns a defined result. The quotient is forced to the most negative word and the overflow output is raised. When recording is enabled, the condition field reports "less than" and the summary-overflow bit is set. Recording enable and the incoming summary-overflow bit are captured together with the operands.

Operands enter through a valid/ready handshake. `start_ready` is high only while the divider is idle. A request presented while it is low is not taken, and its operands have no effect. The result side has no back-pressure. `done` is a one-cycle pulse, and `quot`, `cr` and `ovf` hold their values until the next pulse. A new request may be accepted in the same cycle that `done` is high.

Top module: `sdiv_word`

## Requirements
- R1: `start_ready` is 1 whenever the divider is idle. An operation is accepted on a rising clock edge where both `start_valid` and `start_ready` are 1. After acceptance, `start_ready` stays 0 until the cycle in which `done` is 1.
- R2: `done` is 1 for exactly one cycle. That cycle follows the 33rd rising edge after the accepting edge.
- R3: When neither overflow case applies, `quot` is the signed quotient truncated toward zero. Its sign is the XOR of the operand signs, and a zero magnitude is never given a negative sign.
- R4: A divisor of zero gives `ovf`=1 and `quot`=0x80000000, whatever the dividend.
- R5: A dividend of 0x80000000 with a divisor of 0xFFFFFFFF (minus one) gives `ovf`=1 and `quot`=0x80000000. Every other pair gives `ovf`=0.
- R6: The condition field is laid out as `cr[3]`=LT, `cr[2]`=GT, `cr[1]`=EQ and `cr[0]`=SO. On overflow with recording enabled, `cr` becomes 4'b1001: LT=1, GT=0, EQ=0, and SO=1 as the OR of the captured SO and the overflow.
- R7: On a normal result with recording enabled, exactly one of LT, GT and EQ is set, from the signed comparison of `quot` with zero. SO equals the captured `so_in`.
- R8: When recording is disabled for an operation, `cr` keeps its previous value through that operation's `done`. This holds for overflow results too.
- R9: After reset, `start_ready`=1, `done`=0, `quot`=0, `cr`=0 and `ovf`=0.
- R10: `quot`, `cr` and `ovf` change only in a cycle in which `done` is 1.
- R11: A request presented while `start_ready` is 0 is ignored. The running operation completes with the result of the operands it accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request to divide the presented operands |
| start_ready | output | 1 | Divider idle; a request is taken on this edge |
| num | input | 32 | Dividend, two's complement |
| den | input | 32 | Divisor, two's complement |
| rec_en | input | 1 | Update the condition field for this operation |
| so_in | input | 1 | Current summary-overflow bit |
| quot | output | 32 | Quotient of the last completed operation |
| cr | output | 4 | Condition field {LT, GT, EQ, SO} |
| ovf | output | 1 | Last completed operation overflowed |
| done | output | 1 | One-cycle result pulse |

## Verification
The assertions assume that `start_valid` and the operands are driven synchronously and stay stable around each rising edge. They also assume that `rec_en` is meaningful only on the accepting edge, which is why the checker captures it itself on that edge. The stimulus drives every input on the falling edge and starts a new request only after sampling `start_ready` high. It holds `start_valid` for a single cycle per accepted operation. Requests made during a busy period are deliberately given different operands and are kept up for several cycles, so that any leak into the result changes the quotient.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // Condition field, most significant bit first: LT, GT, EQ, SO.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

  localparam crf_t CRF_OVF = '{lt: 1'b1, gt: 1'b0, eq: 1'b0, so: 1'b1};
endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: magnitudes, result sign and overflow detection.
module sdiv_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         neg,
  output logic         ovf
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  always_comb begin
    a_mag = a[W-1] ? (~a + 1'b1) : a;
    b_mag = b[W-1] ? (~b + 1'b1) : b;
    neg   = a[W-1] ^ b[W-1];
    ovf   = (b == '0) || ((a == MINV) && (b == ONES));
  end
endmodule

// File: rtl/sdiv_core.sv
// Radix-2 restoring divider on unsigned magnitudes; one bit per cycle.
module sdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_mag,
  input  logic [W-1:0] b_mag,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] q_mag
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]    rem;
  logic [W-1:0]  q;
  logic [W-1:0]  d;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;
  logic          take;

  always_comb begin
    shifted = {rem[W-1:0], q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, d};
    take    = ~diff[W+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      q   <= '0;
      d   <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !run && !fin) begin
        rem <= '0;
        q   <= a_mag;
        d   <= b_mag;
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        rem <= take ? diff[W:0] : shifted;
        q   <= {q[W-2:0], take};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign busy  = run | fin;
  assign q_mag = q;
endmodule

// File: rtl/sdiv_flags.sv
// Final sign, overflow substitution and condition-field update.
module sdiv_flags
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic         neg,
  input  logic         ovf,
  input  logic         rec,
  input  logic         so,
  input  crf_t         cr_prev,
  output logic [W-1:0] quot_n,
  output crf_t         cr_n
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  crf_t cr_calc;

  always_comb begin
    if (ovf) quot_n = MINV;
    else     quot_n = neg ? (~q_mag + 1'b1) : q_mag;

    if (ovf) begin
      cr_calc = CRF_OVF;
    end else begin
      cr_calc.lt = quot_n[W-1];
      cr_calc.eq = (quot_n == '0);
      cr_calc.gt = ~quot_n[W-1] & (quot_n != '0);
      cr_calc.so = so;
    end
    cr_n = rec ? cr_calc : cr_prev;
  end
endmodule

// File: rtl/sdiv_word.sv
module sdiv_word
  import sdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  input  logic         rec_en,
  input  logic         so_in,
  output logic [W-1:0] quot,
  output logic [3:0]   cr,
  output logic         ovf,
  output logic         done
);
  logic         accept;
  logic [W-1:0] a_mag, b_mag, q_mag, quot_n;
  logic         neg_c, ovf_c;
  logic         busy, fin;
  logic         neg_r, ovf_r, rec_r, so_r;
  crf_t         cr_q, cr_n;

  assign start_ready = ~busy;
  assign accept      = start_valid & start_ready;

  sdiv_prep #(.W(W)) u_prep (
    .a(num), .b(den), .a_mag(a_mag), .b_mag(b_mag), .neg(neg_c), .ovf(ovf_c)
  );

  sdiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .a_mag(a_mag), .b_mag(b_mag),
    .busy(busy), .fin(fin), .q_mag(q_mag)
  );

  sdiv_flags #(.W(W)) u_flags (
    .q_mag(q_mag), .neg(neg_r), .ovf(ovf_r), .rec(rec_r), .so(so_r),
    .cr_prev(cr_q), .quot_n(quot_n), .cr_n(cr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_r <= 1'b0;
      ovf_r <= 1'b0;
      rec_r <= 1'b0;
      so_r  <= 1'b0;
      quot  <= '0;
      cr_q  <= '0;
      ovf   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        neg_r <= neg_c;
        ovf_r <= ovf_c;
        rec_r <= rec_en;
        so_r  <= so_in;
      end
      if (fin) begin
        quot <= quot_n;
        cr_q <= cr_n;
        ovf  <= ovf_r;
      end
    end
  end

  assign cr = cr_q;
endmodule

// File: rtl/sdiv_word_chk.sv
module sdiv_word_chk #(
  parameter int W   = 32,
  parameter int LAT = W + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_valid,
  input logic         start_ready,
  input logic         rec_en,
  input logic [W-1:0] quot,
  input logic [3:0]   cr,
  input logic         ovf,
  input logic         done
);
  localparam int CW = $clog2(LAT + 2) + 1;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [CW-1:0] cnt;
  logic          inflight, rec_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      inflight <= 1'b0;
      rec_l    <= 1'b0;
    end else if (start_valid && start_ready) begin
      cnt      <= '0;
      inflight <= 1'b1;
      rec_l    <= rec_en;
    end else begin
      if (inflight) cnt <= cnt + 1'b1;
      if (done) inflight <= 1'b0;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inflight && cnt == CW'(LAT)));
  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ovf_quot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (quot == MINV));
  assert_ovf_cr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf && rec_l) |-> (cr == 4'b1001));
  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr[3:1]));
  assert_hold_cr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rec_l) |-> $stable(cr));
  assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quot) && $stable(cr) && $stable(ovf)));
endmodule

bind sdiv_word sdiv_word_chk #(.W(W), .LAT(W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .rec_en(rec_en), .quot(quot), .cr(cr), .ovf(ovf), .done(done)
);

// File: tb/tb_sdiv_word.sv
module tb_sdiv_word;
  localparam int LAT = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] num = '0, den = '0;
  logic        rec_en = 1'b0, so_in = 1'b0;
  logic [31:0] quot;
  logic [3:0]  cr;
  logic        ovf, done;

  always #2 clk = ~clk;

  sdiv_word dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .num(num), .den(den), .rec_en(rec_en), .so_in(so_in),
    .quot(quot), .cr(cr), .ovf(ovf), .done(done)
  );

  typedef struct {
    logic [31:0] q;
    logic [3:0]  cr;
    logic        ovf;
    int          acc;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [3:0]  model_cr = 4'b0000;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: compute the expected result, hand over one request, push it.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic rec, input logic so, input string req,
                        input bit poke_busy);
    exp_t e;
    bit   ov;
    ov = (b == 32'h0) || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    e.q   = ov ? 32'h8000_0000 : 32'($signed(a) / $signed(b));
    e.ovf = ov;
    if (rec) begin
      if (ov) model_cr = 4'b1001;
      else model_cr = {e.q[31], (!e.q[31] && e.q != 0), (e.q == 0), so};
    end
    e.cr  = model_cr;
    e.req = req;
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1; num = a; den = b; rec_en = rec; so_in = so;
    e.acc = cyc + 1;
    sbq.push_back(e);
    @(negedge clk);
    start_valid = 1'b0;
    if (poke_busy) begin
      // R11: requests while busy must be ignored
      for (int i = 0; i < 3; i++) begin
        start_valid = 1'b1; num = ~a; den = 32'd3; rec_en = ~rec; so_in = ~so;
        chk(start_ready == 1'b0, "R1", "ready during busy", 32'(start_ready), 32'd0);
        @(negedge clk);
      end
      start_valid = 1'b0;
    end
  endtask

  // Monitor: compare each result pulse against the head of the queue.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(quot == e.q, e.req, "quot", quot, e.q);
        chk(ovf == e.ovf, e.req, "ovf", 32'(ovf), 32'(e.ovf));
        chk(cr == e.cr, e.req, "cr", 32'(cr), 32'(e.cr));
        chk(cyc == e.acc + LAT, "R2", "latency", 32'(cyc - e.acc), 32'(LAT));
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(start_ready == 1'b1, "R9", "ready", 32'(start_ready), 32'd1);
    chk(done == 1'b0, "R9", "done", 32'(done), 32'd0);
    chk(quot == 32'h0, "R9", "quot", quot, 32'h0);
    chk(cr == 4'h0, "R9", "cr", 32'(cr), 32'h0);
    chk(ovf == 1'b0, "R9", "ovf", 32'(ovf), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready == 1'b1, "R1", "ready when idle", 32'(start_ready), 32'd1);

    run_op(32'd100, 32'd7, 1'b1, 1'b0, "R3", 0);
    run_op(-32'sd100, 32'd7, 1'b1, 1'b0, "R3", 0);
    run_op(32'd100, -32'sd7, 1'b1, 1'b1, "R7", 0);
    run_op(-32'sd100, -32'sd7, 1'b1, 1'b0, "R7", 0);
    run_op(32'd7, 32'd100, 1'b1, 1'b1, "R7", 0);
    run_op(-32'sd7, 32'd2, 1'b1, 1'b0, "R3", 0);
    run_op(32'h8000_0000, 32'd1, 1'b1, 1'b0, "R3", 0);
    run_op(32'h8000_0000, 32'd2, 1'b1, 1'b0, "R3", 0);
    run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5", 0);
    run_op(32'd12345, 32'd0, 1'b1, 1'b0, "R4", 0);
    run_op(32'd5, 32'd1, 1'b0, 1'b0, "R8", 0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6", 0);
    run_op(-32'sd9, 32'd3, 1'b1, 1'b1, "R7", 0);
    run_op(32'd0, 32'd0, 1'b0, 1'b1, "R8", 0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5", 0);
    run_op(32'd1000, 32'd10, 1'b1, 1'b1, "R11", 1);
    run_op(-32'sd1, 32'd0, 1'b1, 1'b1, "R6", 0);

    while (sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R10: outputs steady with no activity
    chk(done == 1'b0, "R10", "done idle", 32'(done), 32'd0);
    chk(quot == 32'h8000_0000, "R10", "quot held", quot, 32'h8000_0000);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule